// File: doc/BRIEF.md
# Reversible-Gate Storage Lanes

This block provides a bank of one-bit storage lanes whose next-state logic is composed only of reversible gates: a 4x4 switch gate, a 4x4 toggle gate and a 2x2 controlled-XOR gate. Each lane holds two elements. The first is a level-enabled data latch. The second is a toggle flip-flop that reacts to rising edges of a shared toggle clock. The state itself sits in ordinary registers that run on the system clock. Constant gate inputs are tied inside the cells. The gate outputs that the state does not use are either routed to debug ports or gathered on wires that go nowhere.

The latch feeds its enable, its stored bit, its data and a constant 0 into the switch gate. The third gate output is the next state, so the latch follows the data while enabled and holds otherwise. When the complement parameter is set, a controlled-XOR gate with a constant-1 control produces the inverted output. The toggle clock is sampled on the system clock. A rising edge seen there flips every lane whose toggle input is 1. A parameter chooses how the toggle cell is built: two switch gates plus one XOR gate, or a single toggle gate that keeps a complementary state pair.

Top module: `rvs_store_top`

## Requirements
- R1: A synchronous active-high `rst` clears every `lat_q` and `tog_q` bit to 0 at the clock edge where it is sampled high.
- R2: At a `clk` edge where `lat_en[i]` is 1, `lat_q[i]` takes the value of `lat_d[i]`.
- R3: At a `clk` edge where `lat_en[i]` is 0, `lat_q[i]` keeps its value whatever `lat_d[i]` is.
- R4: With the complement option on (default), `lat_qn` is always the bitwise inverse of `lat_q`.
- R5: A rising edge of `tog_ck` is one clock edge at which `tog_ck` is sampled 1 after having been sampled 0 at the previous edge. At such an edge, every `tog_q[i]` with `tog_t[i]` = 1 inverts.
- R6: At a rising edge of `tog_ck`, every `tog_q[i]` with `tog_t[i]` = 0 keeps its value.
- R7: When `tog_ck` is steady low, steady high or falling, `tog_q` keeps its value for any `tog_t`.
- R8: If `tog_ck` is already 1 during the first clock edge after reset, that edge does not count as a rising edge.
- R9: `lat_aux[i]` (the spare output of the latch switch gate) equals `lat_q[i]` while `lat_en[i]` is 1 and equals `lat_d[i]` while `lat_en[i]` is 0.
- R10: `tog_flip[i]` (the toggle candidate) always equals `tog_q[i]` XOR `tog_t[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lat_en | input | LANES | Per-lane latch enable |
| lat_d | input | LANES | Per-lane latch data |
| lat_q | output | LANES | Stored latch bits |
| lat_qn | output | LANES | Inverted latch bits (0 when the option is off) |
| lat_aux | output | LANES | Debug: spare switch-gate output of each latch |
| tog_ck | input | 1 | Shared toggle clock, sampled on `clk` |
| tog_t | input | LANES | Per-lane toggle enable |
| tog_q | output | LANES | Toggle flip-flop bits |
| tog_flip | output | LANES | Debug: toggle candidate of each lane |

## Verification
The checker tests, on every cycle, that the latch follows or holds according to the enable. It also tests that the complement and both debug outputs match their gate mapping, that toggle state moves only at a sampled rising edge and then by exactly the toggle mask, and that reset leaves both stores at zero. Only the bench's scenarios can show the ordering effects. These are a toggle clock that is already high when reset ends, a clock held high for several cycles, a falling edge with every toggle bit set, and a mid-run reset followed by renewed counting. For each of these the bench tracks a model of its own and compares the results.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    typedef struct packed {
        logic p;
        logic q;
        logic r;
        logic s;
    } quad_t;

    typedef struct packed {
        logic p;
        logic q;
    } pair_t;

    typedef enum logic {
        TFF_DUAL_SW   = 1'b0,
        TFF_SINGLE_TG = 1'b1
    } tff_kind_e;

    localparam logic TIE_LO = 1'b0;
    localparam logic TIE_HI = 1'b1;

    // 4x4 switch gate: control a steers b or c onto q; r and s add d
    function automatic quad_t sw4(input logic a, input logic b,
                                  input logic c, input logic d);
        quad_t o;
        o.p = a;
        o.q = (~a & b) ^ (a & c);
        o.r = o.q ^ d;
        o.s = (a & b) ^ (~a & c) ^ d;
        return o;
    endfunction

    // 4x4 toggle gate
    function automatic quad_t tg4(input logic a, input logic b,
                                  input logic c, input logic d);
        quad_t o;
        o.p = a;
        o.q = (~b & c) ^ (~a & b) ^ (a & ~b & c);
        o.r = o.q ^ d;
        o.s = (~a & c) ^ (a & b);
        return o;
    endfunction

    // 2x2 controlled XOR
    function automatic pair_t cx2(input logic a, input logic b);
        pair_t o;
        o.p = a;
        o.q = a ^ b;
        return o;
    endfunction

endpackage

// File: rtl/rvs_edge_sense.sv
module rvs_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic ck_in,
    output logic rise
);
    logic prev_q;

    // Reset value 1: a clock already high when reset ends is not an edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= ck_in;
    end

    assign rise = ck_in & ~prev_q;
endmodule

// File: rtl/rvs_dlatch_cell.sv
module rvs_dlatch_cell
    import rvs_pkg::*;
#(
    parameter bit QN_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q,
    output logic qn,
    output logic aux
);
    logic  q_r;
    quad_t g;

    // Inputs in order: enable, stored bit, data, constant 0
    always_comb g = sw4(en, q_r, d, TIE_LO);

    always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= g.r;
    end

    assign q   = q_r;
    assign aux = g.s;

    logic unused_sw;
    assign unused_sw = g.p ^ g.q;

    generate
        if (QN_EN) begin : g_qn
            pair_t cx;
            logic  unused_cx;
            always_comb cx = cx2(q_r, TIE_HI);
            assign qn        = cx.q;
            assign unused_cx = cx.p;
        end else begin : g_no_qn
            assign qn = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rvs_tflop_cell.sv
module rvs_tflop_cell
    import rvs_pkg::*;
#(
    parameter tff_kind_e KIND = TFF_DUAL_SW
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic t,
    output logic q,
    output logic flip
);
    logic q_r;

    generate
        if (KIND == TFF_DUAL_SW) begin : g_dual
            pair_t inv;
            quad_t g_tog;
            quad_t g_sel;
            logic  unused_dual;

            always_comb begin
                inv   = cx2(q_r, TIE_HI);
                // t selects stored bit or its inverse
                g_tog = sw4(t, q_r, inv.q, TIE_LO);
                // the edge strobe selects stored bit or candidate
                g_sel = sw4(rise, q_r, g_tog.q, TIE_LO);
            end

            always_ff @(posedge clk) begin
                if (rst) q_r <= 1'b0;
                else     q_r <= g_sel.r;
            end

            assign flip        = g_tog.r;
            assign unused_dual = inv.p ^ g_tog.p ^ g_tog.s
                               ^ g_sel.p ^ g_sel.q ^ g_sel.s;
        end else begin : g_single
            logic  qb_r;
            quad_t g_tg;
            pair_t mk;
            logic  unused_single;

            always_comb begin
                g_tg = tg4(t, qb_r, q_r, TIE_LO);
                mk   = cx2(g_tg.s, TIE_HI);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r  <= 1'b0;
                    qb_r <= 1'b1;
                end else if (rise) begin
                    q_r  <= g_tg.s;
                    qb_r <= mk.q;
                end
            end

            assign flip          = g_tg.s;
            assign unused_single = g_tg.p ^ g_tg.q ^ g_tg.r ^ mk.p;
        end
    endgenerate

    assign q = q_r;
endmodule

// File: rtl/rvs_store_top.sv
module rvs_store_top
    import rvs_pkg::*;
#(
    parameter int        LANES    = 4,
    parameter bit        QN_EN    = 1'b1,
    parameter tff_kind_e TFF_KIND = TFF_DUAL_SW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lat_en,
    input  logic [LANES-1:0] lat_d,
    output logic [LANES-1:0] lat_q,
    output logic [LANES-1:0] lat_qn,
    output logic [LANES-1:0] lat_aux,
    input  logic             tog_ck,
    input  logic [LANES-1:0] tog_t,
    output logic [LANES-1:0] tog_q,
    output logic [LANES-1:0] tog_flip
);
    logic tog_rise;

    rvs_edge_sense u_edge (
        .clk   (clk),
        .rst   (rst),
        .ck_in (tog_ck),
        .rise  (tog_rise)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            rvs_dlatch_cell #(.QN_EN(QN_EN)) u_lat (
                .clk (clk),
                .rst (rst),
                .en  (lat_en[i]),
                .d   (lat_d[i]),
                .q   (lat_q[i]),
                .qn  (lat_qn[i]),
                .aux (lat_aux[i])
            );

            rvs_tflop_cell #(.KIND(TFF_KIND)) u_tff (
                .clk  (clk),
                .rst  (rst),
                .rise (tog_rise),
                .t    (tog_t[i]),
                .q    (tog_q[i]),
                .flip (tog_flip[i])
            );
        end
    endgenerate
endmodule

// File: rtl/rvs_store_chk.sv
module rvs_store_chk #(
    parameter int LANES = 4,
    parameter bit QN_EN = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] lat_en,
    input logic [LANES-1:0] lat_d,
    input logic [LANES-1:0] lat_q,
    input logic [LANES-1:0] lat_qn,
    input logic [LANES-1:0] lat_aux,
    input logic             tog_ck,
    input logic [LANES-1:0] tog_t,
    input logic [LANES-1:0] tog_q,
    input logic [LANES-1:0] tog_flip
);
    logic ck_seen;
    logic edge_now;

    always_ff @(posedge clk) begin
        if (rst) ck_seen <= 1'b1;
        else     ck_seen <= tog_ck;
    end
    assign edge_now = tog_ck & ~ck_seen;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (lat_q == '0 && tog_q == '0));

    a_r2_latch_follows: assert property (@(posedge clk) disable iff (rst)
        (lat_en != '0) |=> ((lat_q & $past(lat_en)) == ($past(lat_d) & $past(lat_en))));

    a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (lat_en != '1) |=> ((lat_q & ~$past(lat_en)) == ($past(lat_q) & ~$past(lat_en))));

    a_r4_complement: assert property (@(posedge clk) disable iff (rst)
        !QN_EN || (lat_qn == ~lat_q));

    a_r5_toggle_on_edge: assert property (@(posedge clk) disable iff (rst)
        edge_now |=> (tog_q == $past(tog_q ^ tog_t)));

    a_r7_no_edge_holds: assert property (@(posedge clk) disable iff (rst)
        !edge_now |=> $stable(tog_q));

    a_r9_latch_spare: assert property (@(posedge clk) disable iff (rst)
        lat_aux == ((lat_en & lat_q) | (~lat_en & lat_d)));

    a_r10_toggle_candidate: assert property (@(posedge clk) disable iff (rst)
        tog_flip == (tog_q ^ tog_t));
endmodule

bind rvs_store_top rvs_store_chk #(.LANES(LANES), .QN_EN(QN_EN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lat_en   (lat_en),
    .lat_d    (lat_d),
    .lat_q    (lat_q),
    .lat_qn   (lat_qn),
    .lat_aux  (lat_aux),
    .tog_ck   (tog_ck),
    .tog_t    (tog_t),
    .tog_q    (tog_q),
    .tog_flip (tog_flip)
);

// File: tb/rvs_store_top_tb.sv
module rvs_store_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int L = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [L-1:0] lat_en = '0;
    logic [L-1:0] lat_d = '0;
    logic [L-1:0] lat_q, lat_qn, lat_aux;
    logic         tog_ck = 1'b1;
    logic [L-1:0] tog_t = '0;
    logic [L-1:0] tog_q, tog_flip;

    always #(CLK_PERIOD/2) clk = ~clk;

    rvs_store_top #(.LANES(L)) u_dut (
        .clk(clk), .rst(rst), .lat_en(lat_en), .lat_d(lat_d),
        .lat_q(lat_q), .lat_qn(lat_qn), .lat_aux(lat_aux),
        .tog_ck(tog_ck), .tog_t(tog_t), .tog_q(tog_q), .tog_flip(tog_flip)
    );

    typedef struct {
        logic [L-1:0] lq, lqn, laux, tq, tflip;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    logic [L-1:0] m_lq = '0;
    logic [L-1:0] m_tq = '0;
    logic         m_prev = 1'b1;

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic drive(input logic r, input logic [L-1:0] en, input logic [L-1:0] d,
                         input logic ck, input logic [L-1:0] t, input string tag);
        exp_t it;
        @(negedge clk);
        rst = r; lat_en = en; lat_d = d; tog_ck = ck; tog_t = t;
        if (r) begin
            m_lq = '0; m_tq = '0; m_prev = 1'b1;
        end else begin
            m_lq = (m_lq & ~en) | (d & en);
            if (ck && !m_prev) m_tq = m_tq ^ t;
            m_prev = ck;
        end
        it.lq    = m_lq;
        it.lqn   = ~m_lq;
        it.laux  = (en & m_lq) | (~en & d);
        it.tq    = m_tq;
        it.tflip = m_tq ^ t;
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compares one queued item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                n_tests++;
                if ({lat_q, lat_qn, lat_aux, tog_q, tog_flip} !==
                    {it.lq, it.lqn, it.laux, it.tq, it.tflip}) begin
                    n_fail++;
                    $display("FAIL %s: act q=%h qn=%h aux=%h tq=%h flip=%h exp q=%h qn=%h aux=%h tq=%h flip=%h",
                             it.tag, lat_q, lat_qn, lat_aux, tog_q, tog_flip,
                             it.lq, it.lqn, it.laux, it.tq, it.tflip);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act running exp finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state, toggle clock held high throughout reset
        drive(1, 4'hF, 4'hF, 1, 4'hF, "R1 reset");
        drive(1, 4'hF, 4'hA, 1, 4'hF, "R1 reset");
        // R8 clock already high at reset release
        drive(0, 4'h0, 4'h5, 1, 4'hF, "R8 high at release");
        drive(0, 4'h0, 4'h3, 1, 4'hF, "R7 steady high");
        // R2 transparent, R3 hold, R9 spare output
        drive(0, 4'hF, 4'hA, 1, 4'h0, "R2 load A");
        drive(0, 4'h0, 4'h5, 0, 4'hF, "R3 hold, R9 spare, R7 fall");
        drive(0, 4'h5, 4'hF, 0, 4'hF, "R2/R3 mixed enable, R7 low");
        drive(0, 4'hA, 4'h0, 0, 4'h0, "R2/R3 mixed enable, R4");
        // R5 and R6 edges
        drive(0, 4'h0, 4'h0, 1, 4'h6, "R5/R6 rise mask 6");
        drive(0, 4'h0, 4'hF, 1, 4'hF, "R7 high held");
        drive(0, 4'h0, 4'hF, 0, 4'hF, "R7 falling");
        drive(0, 4'h0, 4'hF, 1, 4'hF, "R5 rise all");
        drive(0, 4'h0, 4'hF, 0, 4'h0, "R7 low");
        drive(0, 4'h0, 4'hF, 1, 4'h0, "R6 rise none");
        // Sweep over clock phase, toggle mask and prior state (R5 R6 R7 R10 R2 R3 R4 R9)
        for (int i = 0; i < 64; i++) begin
            logic [L-1:0] en_v, d_v, t_v;
            logic         ck_v;
            en_v = 4'((i * 3) ^ (i >> 2));
            d_v  = 4'(i * 11 + 1);
            t_v  = 4'(i * 7 + 3);
            ck_v = ((i % 3) == 0) || ((i % 5) == 1);
            drive(0, en_v, d_v, ck_v, t_v, "R5/R6/R7 sweep, R10 candidate");
        end
        // R1 reset mid-run, then counting again
        drive(1, 4'h3, 4'hC, 0, 4'hF, "R1 mid-run reset");
        drive(0, 4'h0, 4'h0, 0, 4'hF, "R7 low after reset");
        drive(0, 4'hF, 4'h9, 1, 4'h9, "R5 rise after reset, R2");
        drive(0, 4'h0, 4'h0, 0, 4'h0, "R3 final hold");
        @(posedge clk);
        #2;
        while (exp_q.size() > 0) begin
            @(posedge clk);
            #2;
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule